// File: doc/BRIEF.md
# Binary Hypercube Node Router

This block is the switch inside one node of a binary hypercube network of `2^DIM` nodes. Each node has a `DIM`-bit address, and its neighbour across link `k` differs from it in address bit `k` alone. The router has `DIM` link ports and one local port (index `DIM`) that injects and ejects traffic. Every flit is a whole single-flit packet, and its destination address sits in the low `DIM` bits.

Each input holds at most one flit in a register. The router XORs the destination with the node address. A zero result sends the flit to the local port. Any other result sends it out on the link that matches the lowest set bit, so the Hamming distance to the destination drops by exactly one on every hop and no route is longer than `DIM` hops. Each output has its own round-robin arbiter over all `DIM+1` inputs. All ports use a valid/ready handshake.

Top module: `hcube_router`

## Requirements
- R1: Right after reset every `out_valid_o` bit is low and every `in_ready_o` bit is high.
- R2: A flit whose low `DIM` bits equal `node_addr_i` is presented on output `DIM` (the local port) with all its bits unchanged.
- R3: A flit whose destination differs from `node_addr_i` is presented on link output `k`, where `k` is the lowest set bit of `node_addr_i ^ dest`.
- R4: While an output shows valid and its ready is low, its valid stays high and its flit stays unchanged on the next cycle.
- R5: An input register holds one flit. In the cycle after a flit is accepted on input `i`, `in_ready_o[i]` is low, and it stays low until that flit leaves through an output handshake.
- R6: Each output grants in round-robin order. After input `w` wins, the next grant goes to the first requesting input found by counting upward (with wrap-around) from `w+1`. From reset the search starts at input 0.
- R7: Flits held on different inputs that target different outputs are presented in the same cycle.
- R8: An output shows at most one granted input at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_addr_i | input | DIM | Address of this node |
| in_valid_i | input | DIM+1 | Flit valid per input (links 0..DIM-1, local = DIM) |
| in_flit_i | input | (DIM+1)*FW | Input flits, port i at bits [i*FW +: FW] |
| in_ready_o | output | DIM+1 | Input can accept a flit |
| out_valid_o | output | DIM+1 | Flit valid per output |
| out_flit_o | output | (DIM+1)*FW | Output flits, port o at bits [o*FW +: FW] |
| out_ready_i | input | DIM+1 | Downstream accepts output flit |

## Verification
The bench checks destinations that differ from the node address in one bit and in several bits. A router that picked the highest set bit, or any other set bit, instead of the lowest would put a multi-bit destination on the wrong link. It holds an output stalled for several cycles. A design that let the grant move would change or drop the flit shown on a stalled output. It serves one lone request and then two competing ones. A fixed-priority arbiter, or one whose pointer did not move past the winner, would serve the pair in the wrong order. A last check runs two flits bound for different outputs at the same time, which exposes any arbitration that is shared across outputs.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  function automatic int unsigned port_count(int unsigned dim);
    return dim + 1;
  endfunction
endpackage

// File: rtl/hcr_in_slot.sv
module hcr_in_slot #(
  parameter int unsigned FW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [FW-1:0] flit_i,
  output logic          ready_o,
  input  logic          pop_i,
  output logic          full_o,
  output logic [FW-1:0] flit_o
);
  logic          full_q;
  logic [FW-1:0] flit_q;

  assign ready_o = !full_q;
  assign full_o  = full_q;
  assign flit_o  = flit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      flit_q <= '0;
    end else if (!full_q && valid_i) begin
      full_q <= 1'b1;
      flit_q <= flit_i;
    end else if (full_q && pop_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hcr_route.sv
module hcr_route #(
  parameter int unsigned DIM = 3,
  parameter int unsigned PW  = 2
) (
  input  logic [DIM-1:0] node_i,
  input  logic [DIM-1:0] dest_i,
  output logic [PW-1:0]  port_o
);
  logic [DIM-1:0] diff;
  assign diff = node_i ^ dest_i;

  // descending scan leaves the lowest differing dimension
  always_comb begin
    port_o = PW'(DIM);
    for (int k = DIM - 1; k >= 0; k--) begin
      if (diff[k]) port_o = PW'(k);
    end
  end
endmodule

// File: rtl/hcr_rr_arb.sv
module hcr_rr_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         hold_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic          lock_q;
  logic [N-1:0]  lgnt_q;
  logic [N-1:0]  pick;
  logic [PW-1:0] win;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    win   = '0;
    for (int off = 0; off < int'(N); off++) begin
      int idx;
      idx = (int'(ptr_q) + off) % int'(N);
      if (!found && req_i[idx]) begin
        found     = 1'b1;
        pick[idx] = 1'b1;
        win       = PW'(idx);
      end
    end
  end

  // a stalled output keeps its grant so the presented flit stays put
  assign gnt_o = lock_q ? lgnt_q : pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      lock_q <= 1'b0;
      lgnt_q <= '0;
    end else begin
      lock_q <= hold_i;
      lgnt_q <= gnt_o;
      if (adv_i) begin
        for (int i = 0; i < int'(N); i++) begin
          if (gnt_o[i]) ptr_q <= PW'((i + 1) % int'(N));
        end
      end
    end
  end

  logic unused_win;
  assign unused_win = ^win;
endmodule

// File: rtl/hcube_router.sv
module hcube_router
  import hcr_pkg::*;
#(
  parameter int unsigned DIM = 3,
  parameter int unsigned FW  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DIM-1:0]                node_addr_i,
  input  logic [port_count(DIM)-1:0]    in_valid_i,
  input  logic [port_count(DIM)*FW-1:0] in_flit_i,
  output logic [port_count(DIM)-1:0]    in_ready_o,
  output logic [port_count(DIM)-1:0]    out_valid_o,
  output logic [port_count(DIM)*FW-1:0] out_flit_o,
  input  logic [port_count(DIM)-1:0]    out_ready_i
);
  localparam int unsigned NP = port_count(DIM);
  localparam int unsigned PW = $clog2(NP);

  logic [NP-1:0]    full;
  logic [NP-1:0]    pop;
  logic [FW-1:0]    slot_flit [NP];
  logic [PW-1:0]    rport     [NP];
  logic [NP-1:0]    req       [NP];
  logic [NP-1:0]    gnt       [NP];
  logic [NP*NP-1:0] gnt_flat;

  for (genvar i = 0; i < NP; i++) begin : g_in
    hcr_in_slot #(.FW(FW)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(in_valid_i[i]),
      .flit_i (in_flit_i[i*FW +: FW]),
      .ready_o(in_ready_o[i]),
      .pop_i  (pop[i]),
      .full_o (full[i]),
      .flit_o (slot_flit[i])
    );
    hcr_route #(.DIM(DIM), .PW(PW)) u_route (
      .node_i(node_addr_i),
      .dest_i(slot_flit[i][DIM-1:0]),
      .port_o(rport[i])
    );
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    for (genvar i = 0; i < NP; i++) begin : g_req
      assign req[o][i] = full[i] && (rport[i] == PW'(o));
    end
    assign out_valid_o[o] = |req[o];

    hcr_rr_arb #(.N(NP)) u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req[o]),
      .hold_i(out_valid_o[o] && !out_ready_i[o]),
      .adv_i (out_valid_o[o] && out_ready_i[o]),
      .gnt_o (gnt[o])
    );
    assign gnt_flat[o*NP +: NP] = gnt[o];

    always_comb begin
      out_flit_o[o*FW +: FW] = '0;
      for (int i = 0; i < int'(NP); i++) begin
        if (gnt[o][i]) out_flit_o[o*FW +: FW] = out_flit_o[o*FW +: FW] | slot_flit[i];
      end
    end
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < int'(NP); o++) begin
      for (int i = 0; i < int'(NP); i++) begin
        if (gnt[o][i] && out_ready_i[o]) pop[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
  parameter int unsigned DIM = 3,
  parameter int unsigned FW  = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [DIM-1:0]         node_addr_i,
  input logic [DIM:0]           in_valid_i,
  input logic [DIM:0]           in_ready_o,
  input logic [DIM:0]           out_valid_o,
  input logic [(DIM+1)*FW-1:0]  out_flit_o,
  input logic [DIM:0]           out_ready_i,
  input logic [(DIM+1)*(DIM+1)-1:0] gnt_flat
);
  localparam int unsigned NP = DIM + 1;

  AST_LOCAL_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o[DIM] |-> (out_flit_o[DIM*FW +: DIM] == node_addr_i)); // R2

  for (genvar k = 0; k < DIM; k++) begin : g_link
    localparam logic [DIM-1:0] LOWM = DIM'((1 << k) - 1);
    logic [DIM-1:0] d;
    assign d = node_addr_i ^ out_flit_o[k*FW +: DIM];
    AST_LOWEST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[k] |-> (d[k] && ((d & LOWM) == '0))); // R3
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[p] && !out_ready_i[p]) |=>
        (out_valid_o[p] && $stable(out_flit_o[p*FW +: FW]))); // R4
    AST_ONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i[p] && in_ready_o[p]) |=> !in_ready_o[p]); // R5
    AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_flat[p*NP +: NP])); // R8
  end
endmodule

bind hcube_router hcr_checker #(.DIM(DIM), .FW(FW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .node_addr_i(node_addr_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_flit_o (out_flit_o),
  .out_ready_i(out_ready_i),
  .gnt_flat   (gnt_flat)
);

// File: tb/hcube_router_tb.sv
module hcube_router_tb;
  localparam int DIM = 3;
  localparam int FW  = 16;
  localparam int NP  = DIM + 1;
  localparam logic [DIM-1:0] NODE = 3'b101;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     in_valid = '0;
  logic [NP*FW-1:0]  in_flit = '0;
  logic [NP-1:0]     in_ready;
  logic [NP-1:0]     out_valid;
  logic [NP*FW-1:0]  out_flit;
  logic [NP-1:0]     out_ready = '1;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hcube_router #(.DIM(DIM), .FW(FW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .node_addr_i(NODE),
    .in_valid_i(in_valid), .in_flit_i(in_flit), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_flit_o(out_flit), .out_ready_i(out_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [12:0] pay, input logic [2:0] dst);
    return {pay, dst};
  endfunction

  // called at a negedge; returns at the negedge after capture
  task automatic send(input logic [NP-1:0] mask, input logic [NP*FW-1:0] flits);
    in_valid = mask;
    in_flit  = flits;
    @(negedge clk);
    in_valid = '0;
  endtask

  function automatic logic [FW-1:0] oflit(input int o);
    return out_flit[o*FW +: FW];
  endfunction

  task automatic t_reset;
    chk(out_valid == '0, "R1 out_valid", 32'(out_valid), 0);
    chk(in_ready == '1, "R1 in_ready", 32'(in_ready), 32'hf);
  endtask

  task automatic t_local_stall;
    logic [FW-1:0] f;
    f = mk(13'h1ab, NODE);
    out_ready = '0;
    send(4'b1000, {f, 48'h0});
    chk(out_valid == 4'b1000, "R2 local valid", 32'(out_valid), 32'h8);
    chk(oflit(3) == f, "R2 local flit", 32'(oflit(3)), 32'(f));
    chk(!in_ready[3], "R5 slot full", 32'(in_ready), 32'h7);
    @(negedge clk); @(negedge clk);
    chk(out_valid[3] && oflit(3) == f, "R4 stalled hold", 32'(oflit(3)), 32'(f));
    chk(!in_ready[3], "R5 still full", 32'(in_ready), 32'h7);
    out_ready = '1;
    @(negedge clk);
    chk(out_valid == '0, "R5 drained", 32'(out_valid), 0);
    chk(in_ready[3], "R5 ready again", 32'(in_ready), 32'hf);
  endtask

  task automatic t_link(input logic [2:0] dst, input int exp_port);
    logic [FW-1:0] f;
    f = mk(13'h0c0 + 13'(dst), dst);
    send(4'b1000, {f, 48'h0});
    chk(out_valid == NP'(1 << exp_port), "R3 link select", 32'(out_valid), 32'(1 << exp_port));
    chk(oflit(exp_port) == f, "R3 link flit", 32'(oflit(exp_port)), 32'(f));
    @(negedge clk);
  endtask

  task automatic t_round_robin;
    out_ready = '0;
    send(4'b1011, {mk(13'd3, NODE), 16'h0, mk(13'd1, NODE), mk(13'd0, NODE)});
    out_ready = '1;
    chk(oflit(3) == mk(13'd0, NODE), "R6 first input0", 32'(oflit(3)), 32'(mk(13'd0, NODE)));
    @(negedge clk);
    chk(oflit(3) == mk(13'd1, NODE), "R6 then input1", 32'(oflit(3)), 32'(mk(13'd1, NODE)));
    @(negedge clk);
    chk(oflit(3) == mk(13'd3, NODE), "R6 then input3", 32'(oflit(3)), 32'(mk(13'd3, NODE)));
    @(negedge clk);
    send(4'b0010, {32'h0, mk(13'd11, NODE), 16'h0});
    chk(oflit(3) == mk(13'd11, NODE), "R6 lone input1", 32'(oflit(3)), 32'(mk(13'd11, NODE)));
    @(negedge clk);
    send(4'b1001, {mk(13'd13, NODE), 32'h0, mk(13'd10, NODE)});
    chk(oflit(3) == mk(13'd13, NODE), "R6 input3 before input0", 32'(oflit(3)), 32'(mk(13'd13, NODE)));
    @(negedge clk);
    chk(oflit(3) == mk(13'd10, NODE), "R6 input0 next", 32'(oflit(3)), 32'(mk(13'd10, NODE)));
    @(negedge clk);
  endtask

  task automatic t_parallel;
    send(4'b0011, {32'h0, mk(13'd21, NODE), mk(13'd20, 3'b001)});
    chk(out_valid == 4'b1100, "R7 two outputs at once", 32'(out_valid), 32'hc);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_local_stall();
    t_link(3'b100, 0);
    t_link(3'b001, 2);
    t_link(3'b111, 1);
    t_link(3'b011, 1);
    t_link(3'b000, 0);
    t_round_robin();
    t_parallel();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule